// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block decides which interrupt a small 8-bit CPU core takes next. It has twelve level-sensitive request lines. Each source has its own enable bit, and one global enable gates all of them. Each source also has a two-bit priority level, built from one bit in a low priority register and the matching bit in a high priority register.

The block tracks which priority levels have a handler in progress. A pending request may interrupt a running handler only when its level is strictly higher than the highest level in progress. The core marks each instruction boundary, and arbitration takes place at that point. At the following clock the block presents a one-cycle take strobe, the source number and the granted level. A return-from-interrupt pulse from the core ends the most recent, highest-level handler.

Top module: `prio_intc`

## Requirements
- R1: After reset, all enable and priority bits are zero, no level is in service and `take_o`, `vec_o` and `lvl_o` are all zero.
- R2: A source whose own enable bit is 0 is never granted.
- R3: Bit 7 of enable register 0 is the global enable. While it is 0, no source is granted, whatever the individual enables hold.
- R4: A source's level is {high bit, low bit}. When eligible requests are at different levels, the highest level is granted, whatever the source index.
- R5: Among eligible requests at the winning level, the lowest source index is granted. The index order is never used between different levels.
- R6: While any level is in service, only a request whose level is strictly greater than the highest in-service level is eligible. Requests at the same or a lower level wait.
- R7: While level 3 is in service, no source is granted.
- R8: If `boundary_i` is high at a rising edge and an eligible request exists, `take_o` is high for exactly the next cycle. In that cycle `vec_o` holds the source index and `lvl_o` its level. While `boundary_i` is low, `take_o` stays low.
- R9: A grant marks its level as in service at the same edge that raises `take_o`.
- R10: A `reti_i` pulse clears the highest in-service level. With nothing in service it has no effect.
- R11: Register writes use `wr_sel_i`: 0 selects enable reg 0, 1 enable reg 1, 2 low priority reg 0, 3 low priority reg 1, 4 high priority reg 0, 5 high priority reg 1. In register 0, bit n maps to source n for n from 0 to 6. In register 1, bit n maps to source n+7 for n from 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 12 | Interrupt request lines, level-sensitive |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 8 | Register write data |
| boundary_i | input | 1 | Instruction boundary; arbitrate on this cycle |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | One-cycle grant strobe |
| vec_o | output | 4 | Granted source index |
| lvl_o | output | 2 | Granted priority level |

## Verification
The assertions assume that the core never raises `reti_i` in the same cycle as `boundary_i`. They also assume it pulses `reti_i` only for a handler it has actually entered. The popping property depends on both of these. The stimulus keeps the return pulse, register writes and boundary strobes in separate cycles. It also pulses the return input only to unwind grants it has already observed, except for one deliberate pulse on an empty in-service mask.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NSRC = 12;
  localparam int NLVL = 4;
  localparam int LVLW = $clog2(NLVL);
  localparam int VECW = $clog2(NSRC);
  localparam int REG0_N = 7;  // sources held in byte 0; bit 7 is the global enable
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int LW    = LVLW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [2:0]                wr_sel_i,
  input  logic [7:0]                wr_data_i,
  output logic                      glob_en_o,
  output logic [N_SRC-1:0]          src_en_o,
  output logic [N_SRC-1:0][LW-1:0]  src_lvl_o
);
  logic             glob_q;
  logic [N_SRC-1:0] en_q, lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) glob_q <= 1'b0;
    else if (wr_en_i && wr_sel_i == 3'd0) glob_q <= wr_data_i[7];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int BYTE = (i < REG0_N) ? 0 : 1;
    localparam int BIT  = (i < REG0_N) ? i : i - REG0_N;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i] <= 1'b0;
        lo_q[i] <= 1'b0;
        hi_q[i] <= 1'b0;
      end else if (wr_en_i) begin
        if (wr_sel_i == 3'(0 + BYTE)) en_q[i] <= wr_data_i[BIT];
        if (wr_sel_i == 3'(2 + BYTE)) lo_q[i] <= wr_data_i[BIT];
        if (wr_sel_i == 3'(4 + BYTE)) hi_q[i] <= wr_data_i[BIT];
      end
    end
    assign src_lvl_o[i] = LW'({hi_q[i], lo_q[i]});
  end

  assign glob_en_o = glob_q;
  assign src_en_o  = en_q;
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int N_LVL = NLVL,
  parameter int LW    = LVLW,
  parameter int VW    = VECW
) (
  input  logic [N_SRC-1:0]          req_i,
  input  logic [N_SRC-1:0]          en_i,
  input  logic                      glob_en_i,
  input  logic [N_SRC-1:0][LW-1:0]  lvl_i,
  input  logic                      busy_i,
  input  logic [LW-1:0]             top_lvl_i,
  output logic                      hit_o,
  output logic [VW-1:0]             win_idx_o,
  output logic [LW-1:0]             win_lvl_o
);
  logic [N_SRC-1:0] elig;
  logic [N_LVL-1:0] lvl_hit;
  logic [LW-1:0]    best;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = req_i[i] & en_i[i] & glob_en_i & (!busy_i || (lvl_i[i] > top_lvl_i));
  end

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    logic [N_SRC-1:0] at_l;
    for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
      assign at_l[i] = elig[i] && (lvl_i[i] == LW'(l));
    end
    assign lvl_hit[l] = |at_l;
  end

  // highest populated level
  always_comb begin
    best = '0;
    for (int l = 0; l < N_LVL; l++) if (lvl_hit[l]) best = LW'(l);
  end

  // fixed rank inside the winning level: lowest index
  always_comb begin
    win_idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (elig[i] && lvl_i[i] == best) win_idx_o = VW'(i);
  end

  assign hit_o     = |elig;
  assign win_lvl_o = best;
endmodule

// File: rtl/prio_intc_isr.sv
module prio_intc_isr
  import prio_intc_pkg::*;
#(
  parameter int N_LVL = NLVL,
  parameter int LW    = LVLW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [LW-1:0]    set_lvl_i,
  input  logic             pop_i,
  output logic [N_LVL-1:0] mask_o,
  output logic             busy_o,
  output logic [LW-1:0]    top_lvl_o
);
  logic [N_LVL-1:0] mask_q, clr, set;

  always_comb begin
    top_lvl_o = '0;
    for (int l = 0; l < N_LVL; l++) if (mask_q[l]) top_lvl_o = LW'(l);
  end

  assign busy_o = |mask_q;

  always_comb begin
    clr = '0;
    set = '0;
    if (pop_i && busy_o) clr[top_lvl_o] = 1'b1;
    if (set_i) set[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q & ~clr) | set;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic            wr_en_i,
  input  logic [2:0]      wr_sel_i,
  input  logic [7:0]      wr_data_i,
  input  logic            boundary_i,
  input  logic            reti_i,
  output logic            take_o,
  output logic [VECW-1:0] vec_o,
  output logic [LVLW-1:0] lvl_o
);
  logic                       glob_en;
  logic [NSRC-1:0]            src_en;
  logic [NSRC-1:0][LVLW-1:0]  src_lvl;
  logic                       hit, busy, grant;
  logic [VECW-1:0]            win_idx;
  logic [LVLW-1:0]            win_lvl, top_lvl;
  logic [NLVL-1:0]            insvc;
  logic                       take_q;
  logic [VECW-1:0]            vec_q;
  logic [LVLW-1:0]            lvl_q;

  prio_intc_regs #(.N_SRC(NSRC), .LW(LVLW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .glob_en_o(glob_en), .src_en_o(src_en), .src_lvl_o(src_lvl)
  );

  prio_intc_arb #(.N_SRC(NSRC), .N_LVL(NLVL), .LW(LVLW), .VW(VECW)) u_arb (
    .req_i, .en_i(src_en), .glob_en_i(glob_en), .lvl_i(src_lvl),
    .busy_i(busy), .top_lvl_i(top_lvl),
    .hit_o(hit), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  assign grant = boundary_i & hit;

  prio_intc_isr #(.N_LVL(NLVL), .LW(LVLW)) u_isr (
    .clk_i, .rst_ni, .set_i(grant), .set_lvl_i(win_lvl), .pop_i(reti_i),
    .mask_o(insvc), .busy_o(busy), .top_lvl_o(top_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      lvl_q  <= '0;
    end else begin
      take_q <= grant;
      if (grant) begin
        vec_q <= win_idx;
        lvl_q <= win_lvl;
      end
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            boundary_i,
  input logic            reti_i,
  input logic            take_o,
  input logic [VECW-1:0] vec_o,
  input logic [LVLW-1:0] lvl_o,
  input logic            glob_en,
  input logic [NLVL-1:0] insvc
);
  a_r8_take_after_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));

  a_r8_vec_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_o < VECW'(NSRC)));

  a_r3_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(glob_en));

  a_r9_level_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> insvc[lvl_o]);

  a_r6_strictly_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (($past(insvc) >> lvl_o) == '0));

  a_r7_top_level_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !$past(insvc[NLVL-1]));

  a_r10_reti_pops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !boundary_i && insvc != '0) |=>
      ($countones(insvc) == $countones($past(insvc)) - 1));

  a_r10_reti_empty_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !boundary_i && insvc == '0) |=> (insvc == '0));
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .boundary_i(boundary_i), .reti_i(reti_i),
  .take_o(take_o), .vec_o(vec_o), .lvl_o(lvl_o), .glob_en(glob_en), .insvc(insvc)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  import prio_intc_pkg::*;

  typedef struct packed {
    logic            take;
    logic [VECW-1:0] vec;
    logic [LVLW-1:0] lvl;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] req = '0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_sel = '0;
  logic [7:0]      wr_data = '0;
  logic            boundary = 1'b0;
  logic            reti = 1'b0;
  logic            take;
  logic [VECW-1:0] vec;
  logic [LVLW-1:0] lvl;

  int checks = 0;
  int errors = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  prio_intc u_prio_intc (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .boundary_i(boundary), .reti_i(reti),
    .take_o(take), .vec_o(vec), .lvl_o(lvl)
  );

  // monitor: compares one expected item per arbitration
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (take !== e.take || (e.take && (vec !== e.vec || lvl !== e.lvl))) begin
        errors++;
        $display("FAIL %s: take=%0b vec=%0d lvl=%0d expected take=%0b vec=%0d lvl=%0d",
                 t, take, vec, lvl, e.take, e.vec, e.lvl);
      end
    end else if (rst_n && take === 1'b1) begin
      checks++;
      errors++;
      $display("FAIL R8: unexpected take vec=%0d expected no take", vec);
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic arb(input logic t, input int v, input int l, input string tag);
    exp_t e;
    e.take = t; e.vec = VECW'(v); e.lvl = LVLW'(l);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(10 * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (take !== 1'b0 || vec !== '0 || lvl !== '0) begin
      errors++;
      $display("FAIL R1: take=%0b vec=%0d lvl=%0d expected 0 0 0", take, vec, lvl);
    end
    // R1: enables reset to zero -> nothing granted
    req = '1;
    arb(1'b0, 0, 0, "R1 enables cleared");

    // R11: enable all sources plus global
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h1F);
    req = '0;
    req[5] = 1'b1; req[9] = 1'b1;
    arb(1'b1, 5, 0, "R5 lowest index at level 0");
    arb(1'b0, 0, 0, "R6 same level waits");
    pop();
    // R8: boundary low -> no strobe
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (take !== 1'b0) begin
        errors++;
        $display("FAIL R8: take=%0b with boundary low, expected 0", take);
      end
    end
    arb(1'b1, 5, 0, "R10 reti freed level 0");
    pop();

    // R3: global off
    wr(3'd0, 8'h7F);
    arb(1'b0, 0, 0, "R3 global enable off");
    wr(3'd0, 8'hF7);  // R2: source 3 disabled
    req = '0; req[3] = 1'b1;
    arb(1'b0, 0, 0, "R2 source disabled");
    wr(3'd0, 8'hFF);

    // R4: source 10 level 2, source 1 level 1
    wr(3'd5, 8'h08);
    wr(3'd2, 8'h02);
    req = '0; req[0] = 1'b1; req[1] = 1'b1; req[10] = 1'b1;
    arb(1'b1, 10, 2, "R4 higher level beats lower index");
    arb(1'b0, 0, 0, "R6 lower level blocked by level 2");
    // source 11 level 3
    wr(3'd3, 8'h10);
    wr(3'd5, 8'h18);
    req[11] = 1'b1;
    arb(1'b1, 11, 3, "R6 level 3 preempts level 2");
    // source 2 level 3
    wr(3'd2, 8'h06);
    wr(3'd4, 8'h04);
    req[2] = 1'b1;
    arb(1'b0, 0, 0, "R7 level 3 in service blocks all");
    pop();  // leaves level 2
    arb(1'b1, 2, 3, "R5 lowest index among level 3");
    pop();
    pop();  // empty
    arb(1'b1, 2, 3, "R9 mask cleared after two returns");
    pop();
    pop();  // on empty mask: no effect
    req = '0; req[0] = 1'b1;
    arb(1'b1, 0, 0, "R10 empty return harmless");
    arb(1'b0, 0, 0, "R9 level 0 now in service");
    pop();

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule